// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is the host side of a link to a three-wire serial 10-bit analog-to-digital converter. A one-cycle start request opens a frame. The controller pulls the active-low chip select low, and that starts a conversion in the converter. The controller then toggles a serial clock at a programmed rate. On each falling edge of that clock it samples the converter's data line. Each frame carries three leading zero bits and then ten result bits, most significant bit first, in unipolar straight binary.

When the frame completes, the controller does four things:
- it releases chip select;
- it presents the 10-bit result with a one-cycle valid strobe;
- it raises an error flag if any of the three leading bits was not zero;
- it enforces a short idle gap before the next frame.

The controller also drives the converter's active-low shutdown line from a power-down request. A power-down request ends a frame that is in progress. While power-down is held, and for a fixed settling interval after it is released, start requests are refused.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While `rst_n` is held low and in the cycle after it is released, `cs_n_o`=1, `sclk_o`=0, `valid_o`=0, `busy_o`=0, `frame_err_o`=0 and `result_o`=0. With `pwr_down_i`=0, `shdn_n_o`=1.
- R2: A start is accepted when the following are all true at a clock edge: `start_i`=1, the controller is idle, `pwr_down_i`=0 and the wake interval has elapsed. After an accepted start, `cs_n_o` is 0 and `busy_o` is 1 from the next cycle.
- R3: `sclk_o` is 0 whenever `cs_n_o` is 1. Within a frame, each half period of `sclk_o` lasts H system clocks. The first rising edge comes H cycles after `cs_n_o` falls. A frame has exactly 13 rising edges, so `cs_n_o` stays low for 26·H cycles and `sclk_o` is high for 13·H of them.
- R4: `sdata_i` is sampled once at each falling edge of `sclk_o`, 13 samples per frame. The last 10 samples, first sample as MSB, form `result_o`. In the cycle of the 13th falling edge, `cs_n_o` returns to 1, `busy_o` drops and `valid_o` pulses high for exactly one cycle. `result_o` then holds until the next valid pulse.
- R5: `frame_err_o` is updated with each valid pulse. It is 1 if any of the first three samples of the frame was 1, and 0 otherwise. `result_o` is delivered either way.
- R6: A start request is ignored while a frame is in progress, and during the 2·H cycles after the valid pulse. It causes neither a new chip-select fall nor an extra clock edge.
- R7: `shdn_n_o` equals the inverse of `pwr_down_i`, one cycle later. While `pwr_down_i` is 1, start requests are ignored and `cs_n_o` stays 1.
- R8: If `pwr_down_i` rises during a frame, then from the next cycle `cs_n_o`=1, `sclk_o`=0 and `busy_o`=0. That frame produces no valid pulse.
- R9: After reset, and after `pwr_down_i` falls, start requests are ignored for `WAKE_CYCLES` cycles. After that they are accepted again.
- R10: H is `div_i` sampled at the accepted start. A value of 0 or 1 is treated as 2. Changing `div_i` during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to read one sample |
| div_i | input | DIV_W | Serial clock half period in system clocks (min 2) |
| pwr_down_i | input | 1 | Power-down request |
| sdata_i | input | 1 | Converter serial data line |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idles low |
| shdn_n_o | output | 1 | Active-low converter shutdown |
| busy_o | output | 1 | Frame in progress |
| valid_o | output | 1 | One-cycle result strobe |
| result_o | output | DATA_W | Conversion result |
| frame_err_o | output | 1 | Leading bits were not all zero |

## Verification
The bench builds the block with `DIV_W`=4 and `WAKE_CYCLES`=16, with the other parameters at their defaults. With these values it can run frames at H=2 and at H=5, and it can apply a divider of 0 to show the floor of 2. The short wake interval lets it probe the refusal window directly after a release and then see the first accepted start. A behavioural converter model shifts a chosen 13-bit word out after each rising clock edge. This lets the bench inject faulty leading bits, extra starts inside a frame and inside the gap, and a power-down in the middle of a frame.

// File: rtl/adc_rd_pkg.sv
// Package: shared constants and the frame state type for the serial ADC
// readout controller. Assumes a frame = fixed preamble + data bits.
package adc_rd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_GAP    = 2'd2
    } frame_state_t;
endpackage

// File: rtl/adc_rd_clkgen.sv
// Half-period timer for the serial clock. On load it captures the divider
// (floored at 2) and then, while run is high, emits a one-cycle tick every
// H system clocks. Assumes DIV_W >= 2.
module adc_rd_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    localparam logic [DIV_W-1:0] HALF_MIN = DIV_W'(2);

    logic [DIV_W-1:0] half_q;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] half_eff;

    // Apply the minimum half period to the requested divider.
    always_comb begin
        half_eff = (div_i < HALF_MIN) ? HALF_MIN : div_i;
    end

    // Count down the half period and reload after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= HALF_MIN;
            cnt_q  <= '0;
        end else if (load_i) begin
            half_q <= half_eff;
            cnt_q  <= half_eff - DIV_W'(1);
        end else if (run_i) begin
            if (cnt_q == '0) cnt_q <= half_q - DIV_W'(1);
            else             cnt_q <= cnt_q - DIV_W'(1);
        end
    end

    // Tick when the running count expires.
    always_comb begin
        tick_o = run_i && !load_i && (cnt_q == '0);
    end

    // R10: the captured half period never drops below the floor
    assert_half_floor_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (half_q >= HALF_MIN));
endmodule

// File: rtl/adc_rd_power.sv
// Shutdown driver and wake timer. Drives the converter's active-low shutdown
// line from the power-down request. It holds off conversions during
// power-down and for WAKE_CYCLES clocks after reset or after release.
// Assumes WAKE_CYCLES >= 1.
module adc_rd_power #(
    parameter int WAKE_CYCLES = 64,
    parameter int WAKE_W      = $clog2(WAKE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_down_i,
    output logic shdn_n_o,
    output logic ready_o
);
    localparam logic [WAKE_W-1:0] WAKE_LOAD = WAKE_W'(WAKE_CYCLES);

    logic [WAKE_W-1:0] wake_q;

    // Register the shutdown line and run the wake countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shdn_n_o <= 1'b1;
            wake_q   <= WAKE_LOAD;
        end else begin
            shdn_n_o <= !pwr_down_i;
            if (pwr_down_i)          wake_q <= WAKE_LOAD;
            else if (wake_q != '0)   wake_q <= wake_q - WAKE_W'(1);
        end
    end

    // Allow a conversion only when powered and settled.
    always_comb begin
        ready_o = (wake_q == '0) && !pwr_down_i;
    end

    // R9: a power-down request always restarts the wake interval
    assert_wake_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down_i |=> (wake_q == WAKE_LOAD));
endmodule

// File: rtl/adc_rd_seq.sv
// Frame sequencer. It accepts starts, drives chip select and the serial
// clock from timer ticks, and shifts in the data line on falling edges. It
// delivers the result, framing flag and valid strobe, then holds a two-tick
// gap. Assumes DATA_W >= 2 and PRE_W >= 1.
module adc_rd_seq
    import adc_rd_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int PRE_W  = 3,
    parameter int FRAME  = PRE_W + DATA_W,
    parameter int CNT_W  = $clog2(FRAME + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              ready_i,
    input  logic              pwr_down_i,
    input  logic              tick_i,
    input  logic              sdata_i,
    output logic              load_o,
    output logic              run_o,
    output logic              cs_n_o,
    output logic              sclk_o,
    output logic              busy_o,
    output logic              valid_o,
    output logic [DATA_W-1:0] result_o,
    output logic              frame_err_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME - 1);

    frame_state_t       state_q;
    logic [CNT_W-1:0]   bit_q;
    logic [FRAME-2:0]   shift_q;
    logic               gap_q;
    logic               accept;

    // Decide whether a start request is taken this cycle.
    always_comb begin
        accept = (state_q == ST_IDLE) && start_i && ready_i;
        load_o = accept;
        run_o  = (state_q != ST_IDLE);
        busy_o = (state_q == ST_ACTIVE);
    end

    // Frame state machine, serial clock, capture and result delivery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cs_n_o      <= 1'b1;
            sclk_o      <= 1'b0;
            bit_q       <= '0;
            shift_q     <= '0;
            gap_q       <= 1'b0;
            valid_o     <= 1'b0;
            result_o    <= '0;
            frame_err_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (pwr_down_i && (state_q != ST_IDLE)) begin
                state_q <= ST_IDLE;
                cs_n_o  <= 1'b1;
                sclk_o  <= 1'b0;
            end else begin
                case (state_q)
                    ST_IDLE: begin
                        if (accept) begin
                            state_q <= ST_ACTIVE;
                            cs_n_o  <= 1'b0;
                            sclk_o  <= 1'b0;
                            bit_q   <= '0;
                        end
                    end
                    ST_ACTIVE: begin
                        if (tick_i) begin
                            if (!sclk_o) begin
                                sclk_o <= 1'b1;
                            end else begin
                                sclk_o  <= 1'b0;
                                shift_q <= {shift_q[FRAME-3:0], sdata_i};
                                bit_q   <= bit_q + CNT_W'(1);
                                if (bit_q == LAST_BIT) begin
                                    state_q     <= ST_GAP;
                                    cs_n_o      <= 1'b1;
                                    gap_q       <= 1'b0;
                                    valid_o     <= 1'b1;
                                    result_o    <= {shift_q[DATA_W-2:0], sdata_i};
                                    frame_err_o <= |shift_q[FRAME-2 -: PRE_W];
                                end
                            end
                        end
                    end
                    ST_GAP: begin
                        if (tick_i) begin
                            if (gap_q) state_q <= ST_IDLE;
                            gap_q <= 1'b1;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    // R3: the serial clock rests low whenever chip select is released
    assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);
    // R3: no frame ever counts past its last bit
    assert_bit_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_q <= CNT_W'(FRAME));
    // R4: the valid strobe lasts a single cycle
    assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    // R2: chip select only falls in response to a start request
    assert_cs_fall_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> $past(start_i));
endmodule

// File: rtl/adc_rd_ctrl.sv
// Top of the serial ADC readout controller. It joins the half-period timer,
// the shutdown/wake logic and the frame sequencer. Assumes a converter that
// updates its data line after each rising serial clock edge.
module adc_rd_ctrl #(
    parameter int DATA_W      = 10,
    parameter int PRE_W       = 3,
    parameter int DIV_W       = 8,
    parameter int WAKE_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              pwr_down_i,
    input  logic              sdata_i,
    output logic              cs_n_o,
    output logic              sclk_o,
    output logic              shdn_n_o,
    output logic              busy_o,
    output logic              valid_o,
    output logic [DATA_W-1:0] result_o,
    output logic              frame_err_o
);
    logic load;
    logic run;
    logic tick;
    logic ready;

    adc_rd_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .run_i  (run),
        .div_i  (div_i),
        .tick_o (tick)
    );

    adc_rd_power #(.WAKE_CYCLES(WAKE_CYCLES)) u_power (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_down_i (pwr_down_i),
        .shdn_n_o   (shdn_n_o),
        .ready_o    (ready)
    );

    adc_rd_seq #(.DATA_W(DATA_W), .PRE_W(PRE_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .ready_i     (ready),
        .pwr_down_i  (pwr_down_i),
        .tick_i      (tick),
        .sdata_i     (sdata_i),
        .load_o      (load),
        .run_o       (run),
        .cs_n_o      (cs_n_o),
        .sclk_o      (sclk_o),
        .busy_o      (busy_o),
        .valid_o     (valid_o),
        .result_o    (result_o),
        .frame_err_o (frame_err_o)
    );

    // R7: the converter is never selected while it is shut down
    assert_shdn_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n_o |-> cs_n_o);
    // R9: a frame only opens once the converter has been awake a while
    assert_cs_needs_power_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> (shdn_n_o && $past(shdn_n_o)));
endmodule

// File: tb/adc_rd_ctrl_test.sv
`timescale 1ns/1ps
module adc_rd_ctrl_test;
    localparam int DATA_W = 10;
    localparam int DIV_W  = 4;
    localparam int WAKE   = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [DIV_W-1:0]  div_i = 4'd2;
    logic              pwr_down_i = 1'b0;
    logic              sdata_i = 1'b0;
    logic              cs_n_o, sclk_o, shdn_n_o, busy_o, valid_o, frame_err_o;
    logic [DATA_W-1:0] result_o;

    int          n_checks = 0;
    int          n_errors = 0;
    logic [12:0] slave_word = '0;
    int          rise_idx = 0;

    always #10 clk = ~clk;

    adc_rd_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W), .WAKE_CYCLES(WAKE)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .div_i(div_i),
        .pwr_down_i(pwr_down_i), .sdata_i(sdata_i), .cs_n_o(cs_n_o),
        .sclk_o(sclk_o), .shdn_n_o(shdn_n_o), .busy_o(busy_o),
        .valid_o(valid_o), .result_o(result_o), .frame_err_o(frame_err_o)
    );

    // Converter model: new bit after each rising edge, reset on select.
    always @(posedge sclk_o or negedge cs_n_o) begin
        if (sclk_o) begin
            if (rise_idx < 13) sdata_i = slave_word[12 - rise_idx];
            rise_idx = rise_idx + 1;
        end else begin
            rise_idx = 0;
            sdata_i  = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One complete frame with measurements; optional extra starts inside it.
    task automatic run_frame(input logic [12:0] word, input logic [DIV_W-1:0] div,
                             input bit poke, input string req);
        int h, cs_low, sc_high, nval, lim;
        logic [DATA_W-1:0] res;
        logic err;
        h = (div < 2) ? 2 : int'(div);
        slave_word = word;
        div_i = div;
        cs_low = 0; sc_high = 0; nval = 0; res = '0; err = 1'b0;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        check(cs_n_o == 1'b0 && busy_o == 1'b1, "R2", "cs_n low and busy after start",
              int'({cs_n_o, busy_o}), 1);
        if (!cs_n_o) cs_low++;
        div_i = 4'd9;   // R10: a change mid-frame must not matter
        lim = 0;
        while (nval == 0 && lim < 1000) begin
            @(negedge clk);
            lim++;
            start_i = poke && (lim == 7 || lim == 20);
            if (!cs_n_o) cs_low++;
            if (sclk_o) sc_high++;
            if (valid_o) begin
                nval++;
                res = result_o;
                err = frame_err_o;
                check(cs_n_o == 1'b1 && busy_o == 1'b0, "R4", "cs_n high, busy low at valid",
                      int'({cs_n_o, busy_o}), 2);
            end
        end
        start_i = 1'b0;
        check(cs_low == 26 * h, "R3", "cs_n low cycles", cs_low, 26 * h);
        check(sc_high == 13 * h, "R3", "sclk high cycles", sc_high, 13 * h);
        check(rise_idx == 13, req, "sclk rising edges", rise_idx, 13);
        check(res == word[9:0], "R4", "result", int'(res), int'(word[9:0]));
        check(err == (|word[12:10]), "R5", "framing flag", int'(err), int'(|word[12:10]));
        @(negedge clk);
        check(valid_o == 1'b0, "R4", "valid lasts one cycle", int'(valid_o), 0);
        check(result_o == word[9:0], "R4", "result held", int'(result_o), int'(word[9:0]));
        idle_cycles(2 * h + 2);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        idle_cycles(3);
        check({cs_n_o, sclk_o, valid_o, busy_o, frame_err_o, shdn_n_o} == 6'b100001 &&
              result_o == '0, "R1", "outputs in reset",
              int'({cs_n_o, sclk_o, valid_o, busy_o, frame_err_o, shdn_n_o}), 33);
        rst_n = 1'b1;
        @(negedge clk);
        check({cs_n_o, sclk_o, valid_o, busy_o, frame_err_o, shdn_n_o} == 6'b100001 &&
              result_o == '0, "R1", "outputs after release",
              int'({cs_n_o, sclk_o, valid_o, busy_o, frame_err_o, shdn_n_o}), 33);
    endtask

    // Starts right after a release are refused, then accepted (R9).
    task automatic t_wake_window(input string what);
        int falls = 0;
        for (int i = 0; i < WAKE - 4; i++) begin
            start_i = 1'b1;
            @(negedge clk);
            if (!cs_n_o) falls++;
        end
        start_i = 1'b0;
        check(falls == 0, "R9", what, falls, 0);
        idle_cycles(6);
    endtask

    task automatic t_gap_ignore;
        int falls = 0;
        slave_word = 13'h0155;
        div_i = 4'd3;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        while (!valid_o) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        for (int i = 0; i < 4; i++) begin
            if (!cs_n_o) falls++;
            @(negedge clk);
        end
        check(falls == 0, "R6", "start in gap ignored", falls, 0);
        idle_cycles(8);
    endtask

    task automatic t_shutdown;
        int falls = 0;
        pwr_down_i = 1'b1;
        @(negedge clk);
        check(shdn_n_o == 1'b0, "R7", "shutdown line low", int'(shdn_n_o), 0);
        for (int i = 0; i < 30; i++) begin
            start_i = 1'b1;
            @(negedge clk);
            if (!cs_n_o) falls++;
        end
        start_i = 1'b0;
        check(falls == 0, "R7", "starts ignored in shutdown", falls, 0);
        pwr_down_i = 1'b0;
        @(negedge clk);
        check(shdn_n_o == 1'b1, "R7", "shutdown line high", int'(shdn_n_o), 1);
        t_wake_window("starts ignored after release");
    endtask

    task automatic t_abort;
        int nval = 0;
        slave_word = 13'h03C3;
        div_i = 4'd4;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        idle_cycles(30);
        pwr_down_i = 1'b1;
        @(negedge clk);
        check({cs_n_o, sclk_o, busy_o} == 3'b100, "R8", "frame aborted",
              int'({cs_n_o, sclk_o, busy_o}), 4);
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            if (valid_o) nval++;
        end
        check(nval == 0, "R8", "no valid after abort", nval, 0);
        pwr_down_i = 1'b0;
        idle_cycles(WAKE + 3);
    endtask

    initial begin
        t_reset();
        t_wake_window("starts ignored after reset");
        run_frame(13'h02A5, 4'd2, 1'b0, "R3");
        run_frame(13'h03FF, 4'd5, 1'b0, "R3");
        run_frame(13'h0000, 4'd0, 1'b0, "R10");
        run_frame(13'h0A5A, 4'd2, 1'b0, "R5");
        run_frame(13'h1000 | 13'h0201, 4'd3, 1'b0, "R5");
        run_frame(13'h0133, 4'd2, 1'b1, "R6");
        t_gap_ignore();
        t_shutdown();
        run_frame(13'h0321, 4'd2, 1'b0, "R9");
        t_abort();
        run_frame(13'h00F0, 4'd2, 1'b0, "R8");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule